// File: doc/BRIEF.md
# Sectored Set-Associative Cache Tag Controller

This block holds the tags and valid state of a set-associative data cache whose tag entries each cover a two-line sector. One tag is shared by two neighbouring 64-byte lines, and each of those lines carries its own valid bit. A sector can therefore be resident while one of its lines is still absent. Load requests arrive as word addresses. A hit returns the addressed 32-bit word on the next cycle. A miss issues a line fill on a simple memory port and returns the word once the fill has landed.

When prefetch is enabled, a demand miss also books a fill of the other line in the same sector. That fill goes out only after demand traffic has been served. Replacement inside a set uses a tree pseudo-LRU. Line data is held in a plain register array inside the block.

Top module: `sectored_cache`

## Requirements
- R1: The request carries a 32-bit-word address. Word-address bits 3:0 pick the word in a 64-byte line, bit 4 (byte bit 6) picks the line within the sector, the next log2(SETS) bits pick the set, and the remaining upper bits are the sector tag.
- R2: A request accepted while `req_ready` is high whose line is present gives `resp_valid`=1, `resp_hit`=1 and the addressed word in the next cycle.
- R3: On a miss the block raises `mem_req_valid` for one cycle with the 64-byte-aligned byte address of the line. The cycle after the fill response arrives, it gives `resp_valid`=1, `resp_hit`=0 and the addressed word taken from that fill.
- R4: If the sector tag matches but the requested line is invalid, only that line is fetched, and the other line of the sector stays resident.
- R5: With `pf_en` high, a demand miss is followed by a fill request for the sibling line (byte address XOR 64), and a later load of that sibling hits.
- R6: With `pf_en` low, no sibling fill is requested, so only demanded lines are ever fetched.
- R7: A booked sibling fill is dropped without a memory request if the sibling line is already valid by the time it would be issued, including the case where a demand fill has already fetched it.
- R8: A demand request waiting in an idle cycle is accepted before a booked prefetch is issued. Only one prefetch is held, and the newest booking replaces an older one.
- R9: At most one memory request is outstanding. No new request is raised until the fill response for the previous one has arrived.
- R10: On a sector miss the victim way is chosen by tree pseudo-LRU, and both of its line valid bits are cleared. From reset, nine sector misses to one set evict the sector installed first.
- R11: After reset `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_en | input | 1 | Enables booking and issuing of sibling-line fills |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_waddr | input | ADDR_W-2 | Word address of the load |
| resp_valid | output | 1 | Load response present |
| resp_hit | output | 1 | Response came from a resident line |
| resp_data | output | 32 | Addressed word |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_addr | output | ADDR_W | Line-aligned byte address of the fill |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | 8*LINE_BYTES | Whole line, word 0 in the low bits |

## Verification
In the cycle after a fill completes, the controller may find both a new demand load and a booked sibling fill waiting. The bench provokes this by presenting the next load in the first idle cycle after a prefetching miss. It then judges the outcome from the order of line addresses seen on the memory port and from whether the earlier sibling later hits or misses. A second collision puts a demand load on exactly the line a prefetch has booked, and the test expects no duplicate fetch of that line.

// File: rtl/sc_pkg.sv
// Shared types of the sectored cache controller.
package sc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DREQ,
        ST_DWAIT,
        ST_PREQ,
        ST_PWAIT,
        ST_DONE
    } sc_state_e;
endpackage

// File: rtl/sc_tag_match.sv
// Compares a sector tag against every way of one set.
// Assumes at most one valid way holds a given tag.
module sc_tag_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 23,
    localparam int LW   = $clog2(WAYS)
) (
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [WAYS-1:0]       vld,
    input  logic [TAG_W-1:0]      key,
    output logic                  hit,
    output logic [LW-1:0]         way
);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == key);
    end

    // Encode the matching way.
    always_comb begin
        way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (eq[i]) way = LW'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/sc_plru.sv
// Tree pseudo-LRU for one set: reports the victim and the state after touching a way.
// Assumes WAYS is a power of two, at least 2. Node n lives at state bit n (heap order);
// bit WAYS-1 is a spare. A node bit of 1 steers the victim search to the upper half.
module sc_plru #(
    parameter int WAYS = 8,
    localparam int LW  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] st,
    input  logic [LW-1:0]   touch,
    output logic [LW-1:0]   victim,
    output logic [WAYS-1:0] nx
);
    // Walk the tree along the node bits to the victim leaf.
    always_comb begin
        int pre;
        int node;
        pre = 0;
        for (int l = 0; l < LW; l++) begin
            node = (1 << l) - 1 + pre;
            pre  = pre * 2 + int'(st[node[LW-1:0]]);
        end
        victim = pre[LW-1:0];
    end

    // Point every node on the touched path away from the touched way.
    always_comb begin
        int pre;
        int node;
        logic [LW-1:0] t;
        nx  = st;
        pre = 0;
        t   = touch;
        for (int l = 0; l < LW; l++) begin
            node = (1 << l) - 1 + pre;
            nx[node[LW-1:0]] = ~t[LW-1];
            pre = pre * 2 + int'(t[LW-1]);
            t   = t << 1;
        end
    end
endmodule

// File: rtl/sectored_cache.sv
// Tag and valid-state controller of a sectored set-associative cache.
// One tag covers two adjacent lines, each with its own valid bit. Misses fill
// one line over a single-outstanding memory port. An optional sibling fill is
// booked in a one-entry slot and issued only when no demand is waiting.
// Assumes SETS and WAYS are powers of two and the memory returns a whole line.
module sectored_cache
    import sc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 4,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int WSEL_W    = OFF_W - 2,
    localparam int IDX_W     = $clog2(SETS),
    localparam int LW        = $clog2(WAYS),
    localparam int WA_W      = ADDR_W - 2,
    localparam int TAG_W     = ADDR_W - OFF_W - 1 - IDX_W,
    localparam int LIDX_W    = IDX_W + LW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WA_W-1:0]   req_waddr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [31:0]       resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data
);
    sc_state_e state_q;

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic              sv_q   [SETS][WAYS];
    logic [1:0]        lv_q   [SETS][WAYS];
    logic [WAYS-1:0]   plru_q [SETS];
    logic [LINE_W-1:0] data_q [SETS*WAYS*2];

    logic [WA_W-1:0]   lk_q;
    logic              pf_pend_q;
    logic [IDX_W-1:0]  pf_set_q, f_set_q;
    logic [LW-1:0]     pf_way_q, f_way_q;
    logic              pf_ln_q,  f_ln_q;
    logic [TAG_W-1:0]  pf_tag_q, f_tag_q;

    // Fields of the registered lookup address.
    logic [WSEL_W-1:0] lk_wsel;
    logic              lk_ln;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    assign lk_wsel = lk_q[WSEL_W-1:0];
    assign lk_ln   = lk_q[WSEL_W];
    assign lk_idx  = lk_q[WSEL_W+1 +: IDX_W];
    assign lk_tag  = lk_q[WA_W-1 -: TAG_W];

    logic [WAYS*TAG_W-1:0] set_tags;
    logic [WAYS-1:0]       set_vld;
    logic                  s_hit;
    logic [LW-1:0]         s_way, victim, tgt_way, rd_way;
    logic [WAYS-1:0]       plru_nx;
    logic                  line_hit, sib_valid, pf_ok;
    logic [LINE_W-1:0]     rd_line;

    // Gather the tags and sector valid bits of the indexed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w*TAG_W +: TAG_W] = tag_q[lk_idx][w];
            set_vld[w]                 = sv_q[lk_idx][w];
        end
    end

    sc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
        .tags (set_tags),
        .vld  (set_vld),
        .key  (lk_tag),
        .hit  (s_hit),
        .way  (s_way)
    );

    sc_plru #(.WAYS(WAYS)) plru_i (
        .st     (plru_q[lk_idx]),
        .touch  (tgt_way),
        .victim (victim),
        .nx     (plru_nx)
    );

    // Lookup outcome and prefetch eligibility.
    always_comb begin
        tgt_way   = s_hit ? s_way : victim;
        line_hit  = s_hit && lv_q[lk_idx][s_way][lk_ln];
        sib_valid = s_hit && lv_q[lk_idx][s_way][~lk_ln];
        pf_ok     = sv_q[pf_set_q][pf_way_q]
                    && (tag_q[pf_set_q][pf_way_q] == pf_tag_q)
                    && !lv_q[pf_set_q][pf_way_q][pf_ln_q];
    end

    // Port outputs decoded from state and the data array.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_DREQ) || (state_q == ST_PREQ);
        mem_req_addr  = {f_tag_q, f_set_q, f_ln_q, {OFF_W{1'b0}}};
        rd_way        = (state_q == ST_DONE) ? f_way_q : s_way;
        rd_line       = data_q[{lk_idx, rd_way, lk_ln}];
        resp_data     = rd_line[{lk_wsel, 5'b0} +: 32];
        resp_valid    = ((state_q == ST_LOOKUP) && line_hit) || (state_q == ST_DONE);
        resp_hit      = (state_q == ST_LOOKUP);
    end

    // Control state, valid bits, replacement state and the prefetch slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lk_q      <= '0;
            pf_pend_q <= 1'b0;
            pf_set_q  <= '0;
            pf_way_q  <= '0;
            pf_ln_q   <= 1'b0;
            pf_tag_q  <= '0;
            f_set_q   <= '0;
            f_way_q   <= '0;
            f_ln_q    <= 1'b0;
            f_tag_q   <= '0;
            for (int s = 0; s < SETS; s++) begin
                plru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    sv_q[s][w] <= 1'b0;
                    lv_q[s][w] <= 2'b00;
                end
            end
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lk_q    <= req_waddr;
                        state_q <= ST_LOOKUP;
                    end else if (pf_pend_q) begin
                        pf_pend_q <= 1'b0;
                        if (pf_en && pf_ok) begin
                            f_set_q <= pf_set_q;
                            f_way_q <= pf_way_q;
                            f_ln_q  <= pf_ln_q;
                            f_tag_q <= pf_tag_q;
                            state_q <= ST_PREQ;
                        end
                    end
                end
                ST_LOOKUP: begin
                    plru_q[lk_idx] <= plru_nx;
                    if (line_hit) begin
                        state_q <= ST_IDLE;
                    end else begin
                        f_set_q <= lk_idx;
                        f_way_q <= tgt_way;
                        f_ln_q  <= lk_ln;
                        f_tag_q <= lk_tag;
                        state_q <= ST_DREQ;
                        if (!s_hit) begin
                            sv_q[lk_idx][tgt_way] <= 1'b1;
                            lv_q[lk_idx][tgt_way] <= 2'b00;
                        end
                        if (pf_en && !sib_valid) begin
                            pf_pend_q <= 1'b1;
                            pf_set_q  <= lk_idx;
                            pf_way_q  <= tgt_way;
                            pf_ln_q   <= ~lk_ln;
                            pf_tag_q  <= lk_tag;
                        end
                    end
                end
                ST_DREQ: state_q <= ST_DWAIT;
                ST_PREQ: state_q <= ST_PWAIT;
                ST_DWAIT: begin
                    if (mem_rsp_valid) begin
                        lv_q[f_set_q][f_way_q][f_ln_q] <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_PWAIT: begin
                    if (mem_rsp_valid) begin
                        lv_q[f_set_q][f_way_q][f_ln_q] <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Tag install on a sector miss and line data capture on a fill.
    always_ff @(posedge clk) begin
        if ((state_q == ST_LOOKUP) && !line_hit && !s_hit)
            tag_q[lk_idx][tgt_way] <= lk_tag;
        if (((state_q == ST_DWAIT) || (state_q == ST_PWAIT)) && mem_rsp_valid)
            data_q[{f_set_q, f_way_q, f_ln_q}] <= mem_rsp_data;
    end
endmodule

// File: rtl/sectored_cache_chk.sv
// Port-level protocol checks of the sectored cache controller.
// Assumes it is attached by the bind statement at the end of this file.
module sectored_cache_chk #(
    parameter int OFF_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             mem_req_valid,
    input logic [OFF_W-1:0] req_off,
    input logic             mem_rsp_valid
);
    logic outst_q;

    // Track whether a fill is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)             outst_q <= 1'b0;
        else if (mem_req_valid) outst_q <= 1'b1;
        else if (mem_rsp_valid) outst_q <= 1'b0;
    end

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outst_q);

    // R2
    lookup_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !mem_req_valid));

    // R3
    line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (req_off == '0));

    // R3
    miss_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(mem_rsp_valid));

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !resp_valid && !mem_req_valid));
endmodule

bind sectored_cache sectored_cache_chk #(.OFF_W(OFF_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .mem_req_valid (mem_req_valid),
    .req_off       (mem_req_addr[OFF_W-1:0]),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sectored_cache_tb_top.sv
// Self-checking bench: a vector table of loads, then directed collision and eviction tests.
module sectored_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 512;
    localparam logic [31:0] SALT = 32'h5A5A_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_en = 1'b0;
    logic req_valid = 1'b0;
    logic [29:0] req_waddr = '0;
    logic req_ready, resp_valid, resp_hit;
    logic [31:0] resp_data;
    logic mem_req_valid;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sectored_cache dut_i (
        .clk(clk), .rst_n(rst_n), .pf_en(pf_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_waddr(req_waddr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return (a >> 2) ^ SALT;
    endfunction

    // Memory model: logs each request and answers two cycles later.
    int nreq = 0;
    logic [31:0] req_log [64];
    bit busy = 1'b0;
    int cnt = 0;
    logic [31:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            busy = 1'b0;
        end else if (mem_req_valid && !busy) begin
            busy = 1'b1;
            cnt = 2;
            pend_addr = mem_req_addr;
            if (nreq < 64) req_log[nreq] = mem_req_addr;
            nreq++;
        end else if (busy) begin
            cnt--;
            if (cnt == 0) begin
                busy = 1'b0;
                for (int i = 0; i < 16; i++)
                    mem_rsp_data[i*32 +: 32] <= word_of(pend_addr + 32'(4*i));
                mem_rsp_valid <= 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        settle(3);
        rst_n = 1'b1;
    endtask

    task automatic do_load(input logic [31:0] a, input logic pf, output logic hit, output logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        pf_en = pf;
        req_valid = 1'b1;
        req_waddr = a[31:2];
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        hit = resp_hit;
        d = resp_data;
    endtask

    // Vector table: {byte address, prefetch enable, expected hit}.
    localparam int NV = 8;
    localparam logic [33:0] VECS [NV] = '{
        {32'h0000_0004, 1'b1, 1'b0},   // R3 R5 sector miss with sibling booked
        {32'h0000_0048, 1'b1, 1'b1},   // R5 R1 prefetched sibling, word 2
        {32'h0000_0200, 1'b0, 1'b0},   // R6 second sector in set 0
        {32'h0000_0240, 1'b0, 1'b0},   // R4 sector present, line absent
        {32'h0000_0244, 1'b0, 1'b1},   // R4 R2 now present
        {32'h0000_0080, 1'b1, 1'b0},   // R1 set 1
        {32'h0000_00C0, 1'b0, 1'b1},   // R5 sibling in set 1
        {32'h0000_003C, 1'b0, 1'b1}    // R2 R4 last word of first line
    };

    initial begin
        logic hit;
        logic [31:0] d;
        int base;
        do_reset();

        // R11 reset state
        @(negedge clk);
        chk("R11 ready", 32'(req_ready), 32'd1);
        chk("R11 resp", 32'(resp_valid), 32'd0);
        chk("R11 memreq", 32'(mem_req_valid), 32'd0);

        // Table walk
        base = nreq;
        for (int v = 0; v < NV; v++) begin
            do_load(VECS[v][33:2], VECS[v][1], hit, d);
            chk($sformatf("R2/R3 hit vec%0d", v), 32'(hit), 32'(VECS[v][0]));
            chk($sformatf("R1 data vec%0d", v), d, word_of(VECS[v][33:2]));
            settle(10);
        end
        chk("R6 R5 fills in table", 32'(nreq - base), 32'd6);
        chk("R3 first fill addr", req_log[base], 32'h0000_0000);
        chk("R5 sibling fill addr", req_log[base+1], 32'h0000_0040);

        // R8 demand beats booked prefetch; newest booking replaces it
        do_reset();
        base = nreq;
        do_load(32'h0000_0400, 1'b1, hit, d);
        do_load(32'h0000_0600, 1'b1, hit, d);
        settle(12);
        chk("R8 order 0", req_log[base], 32'h0000_0400);
        chk("R8 order 1", req_log[base+1], 32'h0000_0600);
        chk("R8 order 2", req_log[base+2], 32'h0000_0640);
        do_load(32'h0000_0440, 1'b1, hit, d);
        chk("R8 replaced sibling misses", 32'(hit), 32'd0);
        settle(12);
        chk("R8 R7 fill count", 32'(nreq - base), 32'd4);

        // R7 demand on the booked line: no duplicate fetch
        do_reset();
        base = nreq;
        do_load(32'h0000_0800, 1'b1, hit, d);
        do_load(32'h0000_0844, 1'b1, hit, d);
        chk("R7 R4 line miss", 32'(hit), 32'd0);
        chk("R7 data", d, word_of(32'h0000_0844));
        settle(12);
        chk("R7 no duplicate", 32'(nreq - base), 32'd2);

        // R10 pseudo-LRU eviction clears both lines
        do_reset();
        do_load(32'h0000_0200, 1'b0, hit, d);
        do_load(32'h0000_0240, 1'b0, hit, d);
        for (int k = 2; k <= 9; k++) begin
            do_load(32'(k) << 9, 1'b0, hit, d);
        end
        do_load(32'h0000_0400, 1'b0, hit, d);
        chk("R10 survivor hits", 32'(hit), 32'd1);
        do_load(32'h0000_0240, 1'b0, hit, d);
        chk("R10 evicted line1 misses", 32'(hit), 32'd0);
        chk("R10 refill data", d, word_of(32'h0000_0240));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule